// File: doc/BRIEF.md
# Configuration Header Responder for a Display Function

This block answers configuration-space reads and writes for one type-0 function of a display controller. A host-side agent presents a request with a dword address, a write flag, four byte enables and write data. The block returns read data one cycle later together with a valid strobe. It holds the identity words, the command register, three base address registers with fixed sizing masks, the interrupt pin and minimum-grant fields, and one device-specific byte placed just past the standard 64-byte header.

Address decoders downstream of the block take the current value of every implemented BAR and the command register straight from its outputs. Each write that targets a BAR produces a one-cycle notification carrying that BAR's index. The decoders can use it to rebuild their windows. Software discovers the size of each region in the usual way: it writes all ones and reads the value back. Slots for BARs that are not implemented, and the expansion-ROM slot, always read zero, so no further regions and no option ROM are reported.

Top module: `pcicfg_func_hdr`

## Requirements
- R1: Identity words are read-only and ignore writes. Dword 0 reads {DEVICE_ID, VENDOR_ID}, dword 2 reads (24'h030000 << 8) | ASIC_REV, and dword 11 reads {SUBSYS_ID, VENDOR_ID}. Dword 3 reads zero.
- R2: Dword 15 reads 32'h00080100: interrupt line 0 in bits 7:0, interrupt pin 1 in bits 15:8, minimum grant 8 in bits 23:16, maximum latency 0 in bits 31:24. Writes to it are ignored.
- R3: BAR0 (dword 4) is a memory BAR. Only bits 31:24 store write data and bits 23:0 read zero, so writing all ones reads back 32'hFF000000.
- R4: BAR1 (dword 5) is an I/O BAR. Bits 31:8 store write data, bits 7:1 read zero and bit 0 always reads 1, so writing all ones reads back 32'hFFFFFF01. It resets to 32'h00000001.
- R5: BAR2 (dword 6) is a memory BAR. Only bits 31:12 store write data, so writing all ones reads back 32'hFFFFF000.
- R6: Dwords 7, 8, 9 (BAR3 to BAR5), 10, 12 (expansion ROM), 13 and 14 read zero after any write.
- R7: Dword 1 holds the command register in bits 15:0 and reads zero in bits 31:16. It resets to 0. Only bits set in 16'h07FF are writable. Byte enable 0 qualifies bits 7:0 and byte enable 1 qualifies bits 15:8. The value is driven on `cmd_o`.
- R8: Dword 16 (byte offset 0x40) holds an 8-bit device-specific register in bits 7:0. It resets to 8 and is written only when byte enable 0 is set. Bits 31:8 read zero.
- R9: Any dword at index 17 or above reads zero, and writes to it change no register.
- R10: A write to BAR k (k = 0, 1, 2 at dwords 4, 5, 6) raises `bar_chg` for exactly the cycle after the write and drives `bar_chg_idx` = k in that cycle. No other access raises `bar_chg`.
- R11: A read request returns its data on `cfg_rdata` with `cfg_rvalid` high in the following cycle. `cfg_rvalid` is low after a write or an idle cycle.
- R12: BAR writes apply per byte: byte enable n qualifies bits 8n+7:8n. `bar_vals` carries the readable values, BAR k in bits 32k+31:32k, updated in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Access request, one cycle per access |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Dword index into the 256-byte space |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with cfg_rvalid |
| cfg_rvalid | output | 1 | Read data strobe |
| bar_vals | output | 96 | Readable values of BAR0..BAR2 |
| cmd_o | output | 16 | Command register |
| bar_chg | output | 1 | One-cycle BAR write notification |
| bar_chg_idx | output | 2 | Index of the BAR just written |

## Verification
The bench builds the block with its default parameters: the three size masks 16 MB memory, 256-byte I/O and 4 KB memory, a command write mask of 16'h07FF and a device-specific reset of 8. With these values the sizing readbacks differ per BAR, and the I/O type bit is the only hard-wired one. Random accesses cover the whole 64-dword space with random byte enables and a bias toward all-ones data. This exercises partial BAR updates, writes to the standard header that must be ignored, and writes beyond it, against an independent model.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam int DW      = 32;
  localparam int ADDR_W  = 6;
  localparam int NUM_BAR = 3;
  localparam int BAR_BASE = 4;
  localparam int IDX_W   = 2;

  localparam logic [ADDR_W-1:0] A_ID      = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLASS   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SUBSYS  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_INTR    = ADDR_W'(15);
  localparam logic [ADDR_W-1:0] A_DEVSPEC = ADDR_W'(16);

  // Expand four byte enables to a 32-bit lane mask.
  function automatic logic [DW-1:0] lane_mask(input logic [3:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Merge write data into a stored word under lane and write masks.
  function automatic logic [DW-1:0] masked_merge(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] new_v,
                                                 input logic [3:0]    be,
                                                 input logic [DW-1:0] wmask);
    logic [DW-1:0] m;
    m = lane_mask(be) & wmask;
    return (old_v & ~m) | (new_v & m);
  endfunction

  // Value software sees for a BAR: stored address bits plus fixed type bits.
  function automatic logic [DW-1:0] bar_view(input logic [DW-1:0] stored,
                                             input logic [DW-1:0] amask,
                                             input logic [DW-1:0] tbits);
    return (stored & amask) | tbits;
  endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import pcicfg_pkg::*;
#(
  parameter int          IDX   = 0,
  parameter logic [31:0] AMASK = 32'hFF00_0000,
  parameter logic [31:0] TBITS = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] bar_val
);

  logic [DW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (wr_en) addr_q <= masked_merge(addr_q, wdata, be, AMASK);
  end

  assign bar_val = bar_view(addr_q, AMASK, TBITS);

  // R12: a BAR holds its value when no write targets it
  a_r12_bar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bar_val));

  // R4: hard-wired type bits are always visible
  a_r4_type_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_val & TBITS) == TBITS);

  // R3: bits outside the size mask never leave their fixed value after a write
  a_r3_size_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((bar_val & ~(AMASK | TBITS)) == '0));

endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] CMD_WMASK = 16'h07FF,
  parameter logic [7:0]  USER_RST  = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic          wr_user,
  input  logic [3:0]    be,
  input  logic [DW-1:0] wdata,
  output logic [15:0]   cmd_q,
  output logic [7:0]    user_q
);

  logic [DW-1:0] cmd_next;

  assign cmd_next = masked_merge({16'h0, cmd_q}, wdata, be, {16'h0, CMD_WMASK});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      user_q <= USER_RST;
    end else begin
      if (wr_cmd) cmd_q <= cmd_next[15:0];
      if (wr_user && be[0]) user_q <= wdata[7:0];
    end
  end

  // R7: command register changes only through a write to its dword
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(cmd_q));

  // R7: bits outside the writable mask stay zero
  a_r7_cmd_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> ((cmd_q & ~CMD_WMASK) == 16'h0));

  // R8: device-specific byte needs its byte enable
  a_r8_user_be: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_user && be[0]) |=> $stable(user_q));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID = 16'h5A10,
  parameter logic [15:0] SUBSYS_ID = 16'h6987,
  parameter logic [7:0]  ASIC_REV  = 8'h5C,
  parameter logic [7:0]  MIN_GNT   = 8'd8,
  parameter logic [7:0]  INT_PIN   = 8'd1
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_BAR-1:0][DW-1:0] bars,
  input  logic [15:0]                cmd,
  input  logic [7:0]                 user,
  output logic [DW-1:0]              rdata
);

  localparam logic [23:0] CLASS_DISPLAY = 24'h030000;

  function automatic logic [DW-1:0] class_word(input logic [7:0] rev);
    return {CLASS_DISPLAY, 8'h00} | {24'h0, rev};
  endfunction

  function automatic logic [DW-1:0] intr_word(input logic [7:0] pin,
                                              input logic [7:0] gnt);
    return {8'h00, gnt, pin, 8'h00};
  endfunction

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_ID:      rdata = {DEVICE_ID, VENDOR_ID};
      A_CMD:     rdata = {16'h0, cmd};
      A_CLASS:   rdata = class_word(ASIC_REV);
      A_SUBSYS:  rdata = {SUBSYS_ID, VENDOR_ID};
      A_INTR:    rdata = intr_word(INT_PIN, MIN_GNT);
      A_DEVSPEC: rdata = {24'h0, user};
      default: begin
        for (int k = 0; k < NUM_BAR; k++)
          if (addr == ADDR_W'(BAR_BASE + k)) rdata = bars[k];
      end
    endcase
  end

endmodule

// File: rtl/pcicfg_func_hdr.sv
module pcicfg_func_hdr
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID  = 16'h5A10,
  parameter logic [15:0] SUBSYS_ID  = 16'h6987,
  parameter logic [7:0]  ASIC_REV   = 8'h5C,
  parameter logic [7:0]  MIN_GNT    = 8'd8,
  parameter logic [7:0]  INT_PIN    = 8'd1,
  parameter logic [15:0] CMD_WMASK  = 16'h07FF,
  parameter logic [7:0]  USER_RST   = 8'h08,
  parameter logic [31:0] BAR0_AMASK = 32'hFF00_0000,
  parameter logic [31:0] BAR0_TBITS = 32'h0000_0000,
  parameter logic [31:0] BAR1_AMASK = 32'hFFFF_FF00,
  parameter logic [31:0] BAR1_TBITS = 32'h0000_0001,
  parameter logic [31:0] BAR2_AMASK = 32'hFFFF_F000,
  parameter logic [31:0] BAR2_TBITS = 32'h0000_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_req,
  input  logic                   cfg_wr,
  input  logic [5:0]             cfg_addr,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  output logic                   cfg_rvalid,
  output logic [95:0]            bar_vals,
  output logic [15:0]            cmd_o,
  output logic                   bar_chg,
  output logic [1:0]             bar_chg_idx
);

  localparam logic [NUM_BAR-1:0][DW-1:0] AMASKS = {BAR2_AMASK, BAR1_AMASK, BAR0_AMASK};
  localparam logic [NUM_BAR-1:0][DW-1:0] TBITSS = {BAR2_TBITS, BAR1_TBITS, BAR0_TBITS};

  // Named access events, used by logic and assertions alike
  logic                      wr_fire, rd_fire;
  logic [NUM_BAR-1:0]        bar_wr;
  logic                      bar_wr_any;
  logic [IDX_W-1:0]          bar_wr_idx;
  logic                      cmd_wr, user_wr;
  logic [NUM_BAR-1:0][DW-1:0] bar_q;
  logic [7:0]                user_q;
  logic [DW-1:0]             rd_mux;

  assign wr_fire = cfg_req &  cfg_wr;
  assign rd_fire = cfg_req & ~cfg_wr;
  assign cmd_wr  = wr_fire && (cfg_addr == A_CMD);
  assign user_wr = wr_fire && (cfg_addr == A_DEVSPEC);

  generate
    for (genvar g = 0; g < NUM_BAR; g++) begin : g_bar
      assign bar_wr[g] = wr_fire && (cfg_addr == ADDR_W'(BAR_BASE + g));
      cfg_bar_slot #(
        .IDX   (g),
        .AMASK (AMASKS[g]),
        .TBITS (TBITSS[g])
      ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bar_wr[g]),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .bar_val (bar_q[g])
      );
      assign bar_vals[32*g +: 32] = bar_q[g];
    end
  endgenerate

  assign bar_wr_any = |bar_wr;

  always_comb begin
    bar_wr_idx = '0;
    for (int k = 0; k < NUM_BAR; k++)
      if (bar_wr[k]) bar_wr_idx = IDX_W'(k);
  end

  cfg_ctrl_regs #(
    .CMD_WMASK (CMD_WMASK),
    .USER_RST  (USER_RST)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cmd  (cmd_wr),
    .wr_user (user_wr),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .cmd_q   (cmd_o),
    .user_q  (user_q)
  );

  cfg_read_mux #(
    .VENDOR_ID (VENDOR_ID),
    .DEVICE_ID (DEVICE_ID),
    .SUBSYS_ID (SUBSYS_ID),
    .ASIC_REV  (ASIC_REV),
    .MIN_GNT   (MIN_GNT),
    .INT_PIN   (INT_PIN)
  ) u_rmux (
    .addr  (cfg_addr),
    .bars  (bar_q),
    .cmd   (cmd_o),
    .user  (user_q),
    .rdata (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata   <= '0;
      cfg_rvalid  <= 1'b0;
      bar_chg     <= 1'b0;
      bar_chg_idx <= '0;
    end else begin
      cfg_rvalid <= rd_fire;
      if (rd_fire) cfg_rdata <= rd_mux;
      bar_chg <= bar_wr_any;
      if (bar_wr_any) bar_chg_idx <= bar_wr_idx;
    end
  end

  // R10: each BAR write is followed by a notification with its index
  a_r10_chg_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    bar_wr_any |=> (bar_chg && bar_chg_idx == $past(bar_wr_idx)));

  // R10: no notification without a preceding BAR write
  a_r10_chg_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    bar_chg |-> $past(bar_wr_any));

  // R10: at most one BAR decodes per access
  a_r10_one_bar: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bar_wr));

  // R11: read strobe follows a read request, and only a read request
  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> cfg_rvalid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !cfg_rvalid);

  // R9: an access beyond the device-specific dword touches no register
  a_r9_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cfg_addr > A_DEVSPEC) |=> ($stable(bar_vals) && $stable(cmd_o) && $stable(user_q)));

endmodule

// File: tb/pcicfg_func_hdr_test.sv
module pcicfg_func_hdr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req = 1'b0, cfg_wr = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid;
  logic [95:0] bar_vals;
  logic [15:0] cmd_o;
  logic        bar_chg;
  logic [1:0]  bar_chg_idx;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Model state
  logic [31:0] m_bar [3];
  logic [15:0] m_cmd;
  logic [7:0]  m_user;

  localparam logic [31:0] AM [3] = '{32'hFF00_0000, 32'hFFFF_FF00, 32'hFFFF_F000};
  localparam logic [31:0] TB [3] = '{32'h0, 32'h1, 32'h0};

  always #2 clk = ~clk;

  pcicfg_func_hdr uut (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid), .bar_vals(bar_vals),
    .cmd_o(cmd_o), .bar_chg(bar_chg), .bar_chg_idx(bar_chg_idx)
  );

  function automatic string tag_of(input int a);
    if (a == 0 || a == 2 || a == 3 || a == 11) return "R1";
    if (a == 15) return "R2";
    if (a == 4) return "R3";
    if (a == 5) return "R4";
    if (a == 6) return "R5";
    if (a == 1) return "R7";
    if (a == 16) return "R8";
    if (a >= 17) return "R9";
    return "R6";
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] be);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = 8'hFF;
    return r;
  endfunction

  function automatic logic [31:0] expect_rd(input int a);
    case (a)
      0:  return 32'h5A10_1AB5;
      1:  return {16'h0, m_cmd};
      2:  return 32'h0300_005C;
      4, 5, 6: return m_bar[a-4];
      11: return 32'h6987_1AB5;
      15: return 32'h0008_0100;
      16: return {24'h0, m_user};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    for (int k = 0; k < 3; k++)
      check("R12", "bar_vals", bar_vals[32*k +: 32], m_bar[k]);
    check("R7", "cmd_o", {16'h0, cmd_o}, {16'h0, m_cmd});
  endtask

  task automatic do_write(input int a, input logic [3:0] be, input logic [31:0] d);
    cfg_req = 1'b1; cfg_wr = 1'b1; cfg_addr = 6'(a); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 1'b0; cfg_wr = 1'b0;
    if (a >= 4 && a <= 6) begin
      m_bar[a-4] = ((m_bar[a-4] & ~(bytes_of(be) & AM[a-4])) |
                    (d & bytes_of(be) & AM[a-4])) | TB[a-4];
      check("R10", "bar_chg", {31'h0, bar_chg}, 32'h1);
      check("R10", "bar_chg_idx", {30'h0, bar_chg_idx}, 32'(a-4));
    end else begin
      if (a == 1) m_cmd = (m_cmd & ~(bytes_of(be)[15:0] & 16'h07FF)) |
                          (d[15:0] & bytes_of(be)[15:0] & 16'h07FF);
      if (a == 16 && be[0]) m_user = d[7:0];
      check("R10", "bar_chg idle", {31'h0, bar_chg}, 32'h0);
    end
    check("R11", "rvalid after write", {31'h0, cfg_rvalid}, 32'h0);
    check_outputs(tag_of(a));
  endtask

  task automatic do_read(input int a);
    cfg_req = 1'b1; cfg_wr = 1'b0; cfg_addr = 6'(a); cfg_be = 4'h0;
    @(negedge clk);
    cfg_req = 1'b0;
    check("R11", "rvalid", {31'h0, cfg_rvalid}, 32'h1);
    check(tag_of(a), $sformatf("rdata @%0d", a), cfg_rdata, expect_rd(a));
    check("R10", "bar_chg on read", {31'h0, bar_chg}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5EED);
    m_bar[0] = 32'h0; m_bar[1] = 32'h1; m_bar[2] = 32'h0;
    m_cmd = 16'h0; m_user = 8'h08;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R11", "rvalid idle", {31'h0, cfg_rvalid}, 32'h0);
    check("R4", "BAR1 reset", bar_vals[63:32], 32'h0000_0001);
    check_outputs("R12");
    for (int a = 0; a < 20; a++) do_read(a);
    // Sizing writes
    for (int a = 4; a <= 14; a++) do_write(a, 4'hF, 32'hFFFF_FFFF);
    check("R3", "BAR0 size", bar_vals[31:0], 32'hFF00_0000);
    check("R4", "BAR1 size", bar_vals[63:32], 32'hFFFF_FF01);
    check("R5", "BAR2 size", bar_vals[95:64], 32'hFFFF_F000);
    for (int a = 4; a <= 14; a++) do_read(a);
    // Partial BAR write: only byte 3 of BAR2
    do_write(6, 4'b1000, 32'h1200_0000);
    do_read(6);
    // Read-only identity words and interrupt word
    do_write(0, 4'hF, 32'h0); do_write(2, 4'hF, 32'h0);
    do_write(11, 4'hF, 32'h0); do_write(15, 4'hF, 32'hFFFF_FFFF);
    do_read(0); do_read(2); do_read(11); do_read(15);
    // Command with partial enables
    do_write(1, 4'b0010, 32'hFFFF_FFFF); do_read(1);
    do_write(1, 4'b0001, 32'h0000_00A5); do_read(1);
    // Device-specific byte with and without enable
    do_write(16, 4'b1110, 32'h0000_0033); do_read(16);
    do_write(16, 4'b0001, 32'hFFFF_FF5A); do_read(16);
    // High offsets
    do_write(17, 4'hF, 32'hDEAD_BEEF); do_write(63, 4'hF, 32'hFFFF_FFFF);
    do_read(17); do_read(63); do_read(16);
    // Random traffic
    for (int i = 0; i < 600; i++) begin
      int a;
      logic [31:0] d;
      a = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 63)) : int'($urandom_range(0, 17));
      d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      if ($urandom_range(0, 1) == 1) do_write(a, 4'($urandom_range(0, 15)), d);
      else do_read(a);
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R11", "rvalid idle", {31'h0, cfg_rvalid}, 32'h0);
        check("R10", "bar_chg idle", {31'h0, bar_chg}, 32'h0);
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule